// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is an eight-stage register, stages A to H, whose contents can be held, shifted one place in either direction, or loaded in one step from a shared parallel bus. A two-bit mode input picks the action on every rising clock edge. Each shift direction has its own serial input. The stage that falls off the far end is discarded.

The parallel data port is one bidirectional tri-state bus, used both to read the stages and to load them. The block drives the bus with its contents only when both active-low output enables are low and the mode is anything other than parallel load. In load mode the bus is always an input. The first and last stages also have dedicated outputs that are always driven, even while the bus floats. Looping one of these end outputs back into the serial input that feeds the opposite end turns a shift into a rotate.

An active-low clear zeroes every stage at once, without waiting for a clock edge. A registered state output and a drive-enable flag are provided so that surrounding logic can see the contents and check that the bus never has two drivers at once.

Top module: `uni_shreg`

## Requirements
- R1: Mode 2'b00 (hold) leaves all stages unchanged across a rising clock edge.
- R2: Mode 2'b01 shifts toward H. Stage A takes `ser_to_h`, every other stage takes the old value of its neighbour on the A side, and the old H value is lost.
- R3: Mode 2'b10 shifts toward A. Stage H takes `ser_to_a`, every other stage takes the old value of its neighbour on the H side, and the old A value is lost.
- R4: Mode 2'b11 loads all stages from `pbus` on the rising edge. Bus bit 7 (and `state_q` bit 7) is stage A and bit 0 is stage H, so loading 8'b01010101 gives A=0 and H=1.
- R5: When `oe0_n` and `oe1_n` are both low and the mode is not 2'b11, `bus_drive_en` is 1 and `pbus` carries `state_q`.
- R6: When either `oe0_n` or `oe1_n` is high, `bus_drive_en` is 0 and `pbus` is high impedance unless something outside drives it.
- R7: In mode 2'b11 the block never drives `pbus`, whatever the enables are.
- R8: `end_a` always equals stage A and `end_h` always equals stage H, including while the bus is released.
- R9: Low `clr_n` forces all stages to 0 at once, without a clock edge, and keeps them at 0 across clock edges in any mode.
- R10: Feeding `end_h` into `ser_to_h` while shifting toward H, or `end_a` into `ser_to_a` while shifting toward A, rotates the contents. Eight such rotations restore the original value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift toward H, 10 shift toward A, 11 parallel load |
| ser_to_h | input | 1 | Serial bit entering stage A during a shift toward H |
| ser_to_a | input | 1 | Serial bit entering stage H during a shift toward A |
| oe0_n | input | 1 | Bus output enable, active low |
| oe1_n | input | 1 | Second bus output enable, active low |
| pbus | inout | 8 | Shared parallel bus; bit 7 is stage A |
| end_a | output | 1 | Stage A, always driven |
| end_h | output | 1 | Stage H, always driven |
| state_q | output | 8 | Registered contents; bit 7 is stage A |
| bus_drive_en | output | 1 | High when the block is driving `pbus` |

## Verification
Embedded assertions check on every clock cycle that hold keeps the contents, that each shift moves the bits the correct way, that a load captures the bus, and that the drive flag is low whenever an enable is high or a load is in progress. They also check at every falling edge that the register stays zero while clear is asserted. Only the bench's scenarios can show the observable bus levels: that the bus really floats to high impedance and carries the bench's own data during a load. They also show the clear taking effect between clock edges, and that eight feedback shifts bring a pattern back to where it started.

// File: rtl/ushr_pkg.sv
package ushr_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD = 2'b00,
      MODE_TO_H = 2'b01,
      MODE_TO_A = 2'b10,
      MODE_LOAD = 2'b11
   } ushr_mode_e;
endpackage

// File: rtl/ushr_next.sv
// Per-stage next-value selection. Bit WIDTH-1 is stage A, bit 0 is stage H.
module ushr_next
   import ushr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  ushr_mode_e       mode,
   input  logic             ser_to_h,
   input  logic             ser_to_a,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] nxt
);
   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic from_a_side;
      logic from_h_side;

      if (i == TOP) begin : g_first
         assign from_a_side = ser_to_h;
      end else begin : g_mid_a
         assign from_a_side = cur[i+1];
      end

      if (i == 0) begin : g_last
         assign from_h_side = ser_to_a;
      end else begin : g_mid_h
         assign from_h_side = cur[i-1];
      end

      always_comb begin
         unique case (mode)
            MODE_TO_H: nxt[i] = from_a_side;
            MODE_TO_A: nxt[i] = from_h_side;
            MODE_LOAD: nxt[i] = bus_in[i];
            default:   nxt[i] = cur[i];
         endcase
      end
   end
endmodule

// File: rtl/ushr_store.sv
module ushr_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q <= '0;
      else        q <= nxt;
   end

   always @(negedge clk) begin
      if (!clr_n) begin
         AST_CLEAR_ZERO: assert (q == '0); // R9
      end
   end
endmodule

// File: rtl/ushr_busio.sv
module ushr_busio
   import ushr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  ushr_mode_e       mode,
   input  logic             oe0_n,
   input  logic             oe1_n,
   input  logic [WIDTH-1:0] q,
   inout  wire  [WIDTH-1:0] pbus,
   output logic [WIDTH-1:0] bus_in,
   output logic             drv_en
);
   logic enables_on;
   assign enables_on = ~(oe0_n | oe1_n);
   assign drv_en     = enables_on & (mode != MODE_LOAD);
   assign pbus       = drv_en ? q : {WIDTH{1'bz}};
   assign bus_in     = pbus;
endmodule

// File: rtl/uni_shreg.sv
module uni_shreg
   import ushr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [1:0]       mode,
   input  logic             ser_to_h,
   input  logic             ser_to_a,
   input  logic             oe0_n,
   input  logic             oe1_n,
   inout  wire  [WIDTH-1:0] pbus,
   output logic             end_a,
   output logic             end_h,
   output logic [WIDTH-1:0] state_q,
   output logic             bus_drive_en
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("uni_shreg: WIDTH must be at least 2");
   end

   ushr_mode_e       mode_e;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] bus_in;

   assign mode_e = ushr_mode_e'(mode);

   ushr_next #(.WIDTH(WIDTH)) u_next (
      .mode(mode_e), .ser_to_h(ser_to_h), .ser_to_a(ser_to_a),
      .cur(state_q), .bus_in(bus_in), .nxt(nxt)
   );

   ushr_store #(.WIDTH(WIDTH)) u_store (
      .clk(clk), .clr_n(clr_n), .nxt(nxt), .q(state_q)
   );

   ushr_busio #(.WIDTH(WIDTH)) u_bus (
      .mode(mode_e), .oe0_n(oe0_n), .oe1_n(oe1_n), .q(state_q),
      .pbus(pbus), .bus_in(bus_in), .drv_en(bus_drive_en)
   );

   assign end_a = state_q[TOP];
   assign end_h = state_q[0];

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_HOLD) |=> $stable(state_q)); // R1
   AST_SHIFT_TO_H: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_TO_H) |=> (state_q == {$past(ser_to_h), $past(state_q[TOP:1])})); // R2
   AST_SHIFT_TO_A: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_TO_A) |=> (state_q == {$past(state_q[TOP-1:0]), $past(ser_to_a)})); // R3
   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_LOAD) |=> (state_q == $past(pbus))); // R4
   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!clr_n)
      (oe0_n || oe1_n) |-> !bus_drive_en); // R6
   AST_LOAD_NO_DRIVE: assert property (@(posedge clk) disable iff (!clr_n)
      (mode == MODE_LOAD) |-> !bus_drive_en); // R7
endmodule

// File: tb/sim_uni_shreg.sv
`timescale 1ns/1ps
module sim_uni_shreg;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic         ser_to_h = 1'b0, ser_to_a = 1'b0;
   logic         oe0_n = 1'b0, oe1_n = 1'b0;
   logic         tb_drv_en = 1'b0;
   logic [W-1:0] tb_drv = '0;
   wire  [W-1:0] pbus;
   logic         end_a, end_h, bus_drive_en;
   logic [W-1:0] state_q;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string cur_req = "R1";
   bit model[$];   // index 0 = stage A

   assign pbus = tb_drv_en ? tb_drv : {W{1'bz}};

   always #10 clk = ~clk;   // 50 MHz

   uni_shreg #(.WIDTH(W)) u0 (
      .clk(clk), .clr_n(clr_n), .mode(mode), .ser_to_h(ser_to_h), .ser_to_a(ser_to_a),
      .oe0_n(oe0_n), .oe1_n(oe1_n), .pbus(pbus), .end_a(end_a), .end_h(end_h),
      .state_q(state_q), .bus_drive_en(bus_drive_en)
   );

   function automatic logic [W-1:0] model_vec();
      logic [W-1:0] v;
      for (int i = 0; i < W; i++) v[W-1-i] = model[i];
      return v;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [W-1:0] mv;
      logic         exp_drv;
      mv = model_vec();
      exp_drv = !oe0_n && !oe1_n && (mode != 2'b11);
      check(cur_req, state_q, mv);
      check("R8 end_a", {{(W-1){1'b0}}, end_a}, {{(W-1){1'b0}}, model[0]});
      check("R8 end_h", {{(W-1){1'b0}}, end_h}, {{(W-1){1'b0}}, model[W-1]});
      check("R5 drive flag", {{(W-1){1'b0}}, bus_drive_en}, {{(W-1){1'b0}}, exp_drv});
      if (exp_drv)            check("R5 bus data", pbus, mv);
      else if (mode == 2'b11) check("R7 bus input", pbus, tb_drv);
      else                    check("R6 bus float", pbus, {W{1'bz}});
   endtask

   // One clock: inputs applied at a falling edge, model updated at the rising edge,
   // results compared at the next falling edge.
   task automatic cyc(input logic [1:0] m, input logic sh, input logic sa,
                      input logic [W-1:0] d, input logic e0, input logic e1);
      mode = m; ser_to_h = sh; ser_to_a = sa; tb_drv = d;
      tb_drv_en = (m == 2'b11); oe0_n = e0; oe1_n = e1;
      @(posedge clk);
      case (m)
         2'b01: begin model.push_front(sh); void'(model.pop_back()); end
         2'b10: begin void'(model.pop_front()); model.push_back(sa); end
         2'b11: begin model.delete(); for (int i = W-1; i >= 0; i--) model.push_back(d[i]); end
         default: ;
      endcase
      @(negedge clk);
      compare_all();
   endtask

   initial begin : watchdog
      #(20 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] saved;
      for (int i = 0; i < W; i++) model.push_back(1'b0);
      repeat (2) @(negedge clk);
      check("R9 reset state", state_q, '0);
      clr_n = 1'b1;

      // R4: load and bit ordering
      cur_req = "R4";
      cyc(2'b11, 0, 0, 8'b01010101, 0, 0);
      check("R4 A after load", {7'b0, end_a}, 8'd0);
      check("R4 H after load", {7'b0, end_h}, 8'd1);

      // R1: hold with bus driven (R5)
      cur_req = "R1";
      for (int i = 0; i < 3; i++) cyc(2'b00, 1, 1, 8'h00, 0, 0);
      check("R1 hold kept load", state_q, 8'b01010101);

      // R2: shift toward H, bus released by first enable (R6, R8)
      cur_req = "R4";
      cyc(2'b11, 0, 0, 8'b10101010, 1, 0);
      cur_req = "R2";
      cyc(2'b01, 1, 0, 8'h00, 1, 0);
      check("R2 first shift", state_q, 8'b11010101);
      cyc(2'b01, 0, 0, 8'h00, 0, 0);
      cyc(2'b01, 1, 0, 8'h00, 0, 1);
      check("R2 three shifts", state_q, 8'b10110101);

      // R3: shift toward A, bus released by second enable
      cur_req = "R3";
      cyc(2'b10, 0, 1, 8'h00, 0, 1);
      check("R3 first shift", state_q, 8'b01101011);
      cyc(2'b10, 1, 0, 8'h00, 0, 0);
      cyc(2'b10, 0, 1, 8'h00, 1, 1);
      check("R3 three shifts", state_q, 8'b10101101);

      // R7: load with all enable combinations, bus never driven by the block
      cur_req = "R7";
      cyc(2'b11, 0, 0, 8'hC3, 0, 0);
      cyc(2'b11, 0, 0, 8'h3C, 1, 0);
      cyc(2'b11, 0, 0, 8'h96, 0, 1);
      check("R7 last load", state_q, 8'h96);

      // R10: rotate toward H, feedback from end_h
      cur_req = "R10";
      saved = state_q;
      for (int i = 0; i < W; i++) cyc(2'b01, end_h, 0, 8'h00, 0, 0);
      check("R10 rotate toward H restores", state_q, saved);
      cyc(2'b01, end_h, 0, 8'h00, 0, 0);
      check("R10 rotate toward H one step", state_q, {saved[0], saved[W-1:1]});
      saved = state_q;
      for (int i = 0; i < W; i++) cyc(2'b10, 0, end_a, 8'h00, 1, 0);
      check("R10 rotate toward A restores", state_q, saved);

      // alternating serial pattern toward H, then toward A
      cur_req = "R2";
      for (int i = 0; i < W; i++) cyc(2'b01, i[0], 0, 8'h00, 0, 0);
      check("R2 alternating fill", state_q, 8'b10101010);
      cur_req = "R3";
      for (int i = 0; i < W; i++) cyc(2'b10, 0, i[0], 8'h00, 0, 0);
      check("R3 alternating fill", state_q, 8'b01010101);

      // R9: asynchronous clear between edges, then held through an active mode
      cur_req = "R2";
      for (int i = 0; i < W; i++) cyc(2'b01, 1, 0, 8'h00, 0, 0);
      check("R2 all ones", state_q, 8'hFF);
      #2 clr_n = 1'b0;
      mode = 2'b01; ser_to_h = 1'b1;
      #2 check("R9 clear without edge", state_q, 8'h00);
      @(posedge clk); @(negedge clk);
      check("R9 clear beats shift", state_q, 8'h00);
      check("R9 ends cleared", {6'b0, end_a, end_h}, 8'h00);
      model.delete();
      for (int i = 0; i < W; i++) model.push_back(1'b0);
      clr_n = 1'b1;
      cur_req = "R1";
      cyc(2'b00, 1, 1, 8'h00, 0, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule